// File: doc/BRIEF.md
# Memory Protection Region Checker

The block decides, for each memory access, whether the access may proceed and which memory attributes apply to it. Software loads a table of up to sixteen protection regions through a simple write port. Each region has a base address, a power-of-two size and a set of attribute fields. Each access presents an address, an access kind (read, write or instruction fetch) and a privilege flag. One clock cycle later the block returns a permit or fault verdict, the number of the region that matched, a hit flag and the decoded attributes: memory type, cacheable, shareable and execute-never.

Regions may overlap. Where they do, the region with the larger number decides the outcome. Every region is cut into eight equal subregions, and a per-region mask can take any of them out of the match. A global control word turns the whole unit on and off. It also enables a background map that admits privileged accesses which fall outside every region. The configuration port checks each write and drops any write it cannot store correctly.

Top module: `prc_region_check`

## Requirements
- R1: The table holds 16 regions, indexed 0 to 15 by `cfg_idx`. A write with `cfg_idx` of 16 or more is dropped, and `cfg_reject` goes high in the cycle after that write.
- R2: `cfg_size` code n (0 to 27) gives a region of 2^(n+5) bytes, so code 0 is 32 bytes and code 27 is 4 GB. A code above 27 is rejected. An address matches a region when it lies in the range from base to base+size-1.
- R3: A write whose base has any bit set below the region size is rejected. A rejected write leaves the table unchanged.
- R4: When several enabled regions match one address, the highest-numbered region supplies the verdict and the attributes.
- R5: Each region is divided into 8 equal subregions. Subregion k covers the byte offsets from k*size/8 to (k+1)*size/8-1. When bit k of `cfg_srd` is set, subregion k is removed from the region's match, and lower-numbered regions are then searched.
- R6: After reset the unit, the background map and every region are disabled. While the unit is disabled, every access is permitted and reports no hit.
- R7: The access-permission code `cfg_ap` works as follows:
  - 0 allows nothing.
  - 1 allows privileged read and write.
  - 2 adds unprivileged read to code 1.
  - 3 allows read and write to everyone.
  - 5 allows privileged read only.
  - 6 allows read only at both levels.
  - 4 behaves as 5, and 7 behaves as 6.
  - A write needs write permission. A read or a fetch needs read permission.
- R8: An instruction fetch (`acc_kind` 2) that hits a region with `cfg_xn` set faults.
- R9: When the unit is enabled, an access that hits no region is handled as follows:
  - An unprivileged access faults.
  - A privileged access is permitted only if the background map is enabled.
- R10: The memory type is decoded from TEX, C and B:
  - TEX=0, C=0, B=0 gives strongly-ordered, `rsp_mtype` 0.
  - TEX=0, C=0, B=1 gives device, `rsp_mtype` 1.
  - Every other combination gives normal, `rsp_mtype` 2.
  - Normal memory is cacheable when C or B or TEX[2] is set, and shareable when S is set.
  - Strongly-ordered and device memory report shareable and not cacheable.
- R11: The response (`rsp_valid` and all other `rsp_*` outputs) is registered and appears one cycle after `acc_valid`. `rsp_fault` is the inverse of `rsp_permit` while `rsp_valid` is high. On a miss, the region number and all attribute outputs are zero.
- R12: A configuration or control write takes effect for accesses presented in later cycles. An access in the same cycle as the write uses the old table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| acc_priv | input | 1 | Access is privileged |
| cfg_wr | input | 1 | Region write strobe |
| cfg_idx | input | 5 | Region index (16 and above are rejected) |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Size code, size = 2^(code+5) bytes |
| cfg_en | input | 1 | Region enable |
| cfg_b | input | 1 | Bufferable bit |
| cfg_c | input | 1 | Cacheable bit |
| cfg_s | input | 1 | Shareable bit |
| cfg_xn | input | 1 | Execute-never bit |
| cfg_tex | input | 3 | Type extension field |
| cfg_ap | input | 3 | Access-permission code |
| cfg_srd | input | 8 | Subregion disable mask |
| ctl_wr | input | 1 | Control write strobe |
| ctl_unit_en | input | 1 | Unit enable value |
| ctl_bg_en | input | 1 | Background map enable value |
| cfg_reject | output | 1 | Previous region write was dropped |
| rsp_valid | output | 1 | Response valid |
| rsp_permit | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access denied |
| rsp_hit | output | 1 | Some enabled region matched |
| rsp_region | output | 4 | Winning region number |
| rsp_mtype | output | 2 | 0 strongly-ordered, 1 device, 2 normal |
| rsp_cacheable | output | 1 | Region is cacheable |
| rsp_shareable | output | 1 | Region is shareable |
| rsp_xn | output | 1 | Region is execute-never |

## Verification
The checker assumes that every input carries a known value in every cycle. It also assumes that the access kind and privilege seen one cycle before a response are the ones that produced that response, which holds because the response stage is one register deep. The bench changes inputs only on the falling clock edge and drops `acc_valid` between accesses. It never drives kind 3 into a check that relies on fetch semantics. Accesses are issued only after the configuration and control writes they depend on have completed, so every expected verdict is taken against a settled table.

// File: rtl/prc_pkg.sv
package prc_pkg;
   localparam int SIZE_W = 5;
   localparam int SUB_N  = 8;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_ALT   = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      MT_STRONG = 2'd0,
      MT_DEVICE = 2'd1,
      MT_NORMAL = 2'd2,
      MT_SPARE  = 2'd3
   } mem_type_e;

   typedef struct packed {
      logic             en;
      logic             b;
      logic             c;
      logic             s;
      logic             xn;
      logic [2:0]       tex;
      logic [2:0]       ap;
      logic [SUB_N-1:0] srd;
   } region_attr_t;
endpackage

// File: rtl/prc_cfg_store.sv
module prc_cfg_store
   import prc_pkg::*;
#(
   parameter  int NUM_REGIONS = 16,
   parameter  int ADDR_W      = 32,
   localparam int IDX_W       = $clog2(NUM_REGIONS),
   localparam int CIDX_W      = IDX_W + 1,
   localparam int MAX_CODE    = ADDR_W - 5
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cfg_wr,
   input  logic [CIDX_W-1:0]                    cfg_idx,
   input  logic [ADDR_W-1:0]                    cfg_base,
   input  logic [SIZE_W-1:0]                    cfg_size,
   input  region_attr_t                         cfg_attr,
   input  logic                                 ctl_wr,
   input  logic                                 ctl_unit_en,
   input  logic                                 ctl_bg_en,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]   base_q,
   output logic [NUM_REGIONS-1:0][SIZE_W-1:0]   size_q,
   output region_attr_t [NUM_REGIONS-1:0]       attr_q,
   output logic                                 unit_en_q,
   output logic                                 bg_en_q,
   output logic                                 reject_q
);
   logic              idx_ok, size_ok, align_ok, accept;
   logic [ADDR_W-1:0] low_mask;

   always_comb begin
      for (int k = 0; k < ADDR_W; k++)
         low_mask[k] = (k < (int'(cfg_size) + 5));
   end

   assign idx_ok   = cfg_idx < CIDX_W'(NUM_REGIONS);
   assign size_ok  = cfg_size <= SIZE_W'(MAX_CODE);
   assign align_ok = (cfg_base & low_mask) == '0;
   assign accept   = idx_ok && size_ok && align_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q    <= '0;
         size_q    <= '0;
         attr_q    <= '0;
         unit_en_q <= 1'b0;
         bg_en_q   <= 1'b0;
         reject_q  <= 1'b0;
      end else begin
         reject_q <= cfg_wr && !accept;
         for (int i = 0; i < NUM_REGIONS; i++) begin
            if (cfg_wr && accept && cfg_idx == CIDX_W'(i)) begin
               base_q[i] <= cfg_base;
               size_q[i] <= cfg_size;
               attr_q[i] <= cfg_attr;
            end
         end
         if (ctl_wr) begin
            unit_en_q <= ctl_unit_en;
            bg_en_q   <= ctl_bg_en;
         end
      end
   end
endmodule

// File: rtl/prc_region_hit.sv
module prc_region_hit
   import prc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [SIZE_W-1:0] size,
   input  logic              en,
   input  logic [SUB_N-1:0]  srd,
   output logic              hit
);
   logic [ADDR_W-1:0] low_mask;
   logic [5:0]        sub_shift;
   logic [2:0]        sub_sel;
   logic              in_range;

   always_comb begin
      for (int k = 0; k < ADDR_W; k++)
         low_mask[k] = (k < (int'(size) + 5));
   end

   assign sub_shift = {1'b0, size} + 6'd2;
   assign sub_sel   = 3'(addr >> sub_shift);
   assign in_range  = ((addr ^ base) & ~low_mask) == '0;
   assign hit       = en && in_range && !srd[sub_sel];
endmodule

// File: rtl/prc_access_decode.sv
module prc_access_decode
   import prc_pkg::*;
(
   input  logic       unit_en,
   input  logic       bg_en,
   input  logic       hit,
   input  logic       priv,
   input  acc_kind_e  kind,
   input  logic       b,
   input  logic       c,
   input  logic       s,
   input  logic       xn,
   input  logic [2:0] tex,
   input  logic [2:0] ap,
   output logic       permit,
   output mem_type_e  mtype,
   output logic       cacheable,
   output logic       shareable,
   output logic       xn_out
);
   logic      rd_ok, wr_ok, need_ok, active;
   mem_type_e raw_type;

   always_comb begin
      unique case (ap)
         3'd0:       begin rd_ok = 1'b0; wr_ok = 1'b0; end
         3'd1:       begin rd_ok = priv; wr_ok = priv; end
         3'd2:       begin rd_ok = 1'b1; wr_ok = priv; end
         3'd3:       begin rd_ok = 1'b1; wr_ok = 1'b1; end
         3'd4, 3'd5: begin rd_ok = priv; wr_ok = 1'b0; end
         default:    begin rd_ok = 1'b1; wr_ok = 1'b0; end
      endcase
   end

   assign need_ok = (kind == ACC_WRITE) ? wr_ok : rd_ok;
   assign active  = unit_en && hit;

   always_comb begin
      if (!unit_en)
         permit = 1'b1;
      else if (hit)
         permit = need_ok && !((kind == ACC_FETCH) && xn);
      else
         permit = priv && bg_en;
   end

   always_comb begin
      if (tex == 3'd0 && !c)
         raw_type = b ? MT_DEVICE : MT_STRONG;
      else
         raw_type = MT_NORMAL;
   end

   assign mtype     = active ? raw_type : MT_STRONG;
   assign cacheable = active && (raw_type == MT_NORMAL) && (c || b || tex[2]);
   assign shareable = active && ((raw_type != MT_NORMAL) || s);
   assign xn_out    = active && xn;
endmodule

// File: rtl/prc_region_check.sv
module prc_region_check
   import prc_pkg::*;
#(
   parameter  int NUM_REGIONS = 16,
   parameter  int ADDR_W      = 32,
   localparam int IDX_W       = $clog2(NUM_REGIONS),
   localparam int CIDX_W      = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_kind,
   input  logic              acc_priv,
   input  logic              cfg_wr,
   input  logic [CIDX_W-1:0] cfg_idx,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic              cfg_en,
   input  logic              cfg_b,
   input  logic              cfg_c,
   input  logic              cfg_s,
   input  logic              cfg_xn,
   input  logic [2:0]        cfg_tex,
   input  logic [2:0]        cfg_ap,
   input  logic [SUB_N-1:0]  cfg_srd,
   input  logic              ctl_wr,
   input  logic              ctl_unit_en,
   input  logic              ctl_bg_en,
   output logic              cfg_reject,
   output logic              rsp_valid,
   output logic              rsp_permit,
   output logic              rsp_fault,
   output logic              rsp_hit,
   output logic [IDX_W-1:0]  rsp_region,
   output logic [1:0]        rsp_mtype,
   output logic              rsp_cacheable,
   output logic              rsp_shareable,
   output logic              rsp_xn
);
   if (NUM_REGIONS < 2 || NUM_REGIONS > 16) begin : g_bad_regions
      $error("prc_region_check: NUM_REGIONS must lie in 2..16");
   end
   if (ADDR_W < 8 || ADDR_W > 36) begin : g_bad_addr
      $error("prc_region_check: ADDR_W must lie in 8..36");
   end

   logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q;
   logic [NUM_REGIONS-1:0][SIZE_W-1:0] size_q;
   region_attr_t [NUM_REGIONS-1:0]     attr_q;
   region_attr_t                       cfg_attr;
   region_attr_t                       sel_attr;
   logic                               unit_en_q, bg_en_q;
   logic [NUM_REGIONS-1:0]             hit_vec;
   logic [IDX_W-1:0]                   sel_idx;
   logic                               any_hit;
   logic                               permit_c, cach_c, shr_c, xn_c;
   mem_type_e                          mtype_c;

   assign cfg_attr = '{en: cfg_en, b: cfg_b, c: cfg_c, s: cfg_s, xn: cfg_xn,
                       tex: cfg_tex, ap: cfg_ap, srd: cfg_srd};

   prc_cfg_store #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_idx    (cfg_idx),
      .cfg_base   (cfg_base),
      .cfg_size   (cfg_size),
      .cfg_attr   (cfg_attr),
      .ctl_wr     (ctl_wr),
      .ctl_unit_en(ctl_unit_en),
      .ctl_bg_en  (ctl_bg_en),
      .base_q     (base_q),
      .size_q     (size_q),
      .attr_q     (attr_q),
      .unit_en_q  (unit_en_q),
      .bg_en_q    (bg_en_q),
      .reject_q   (cfg_reject)
   );

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
      prc_region_hit #(.ADDR_W(ADDR_W)) u_hit (
         .addr(acc_addr),
         .base(base_q[g]),
         .size(size_q[g]),
         .en  (attr_q[g].en),
         .srd (attr_q[g].srd),
         .hit (hit_vec[g])
      );
   end

   // Ascending scan: a later (higher) match overwrites an earlier one.
   always_comb begin
      sel_idx = '0;
      any_hit = 1'b0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (hit_vec[i]) begin
            sel_idx = IDX_W'(i);
            any_hit = 1'b1;
         end
      end
   end

   assign sel_attr = attr_q[sel_idx];

   prc_access_decode u_decode (
      .unit_en  (unit_en_q),
      .bg_en    (bg_en_q),
      .hit      (any_hit),
      .priv     (acc_priv),
      .kind     (acc_kind_e'(acc_kind)),
      .b        (sel_attr.b),
      .c        (sel_attr.c),
      .s        (sel_attr.s),
      .xn       (sel_attr.xn),
      .tex      (sel_attr.tex),
      .ap       (sel_attr.ap),
      .permit   (permit_c),
      .mtype    (mtype_c),
      .cacheable(cach_c),
      .shareable(shr_c),
      .xn_out   (xn_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_permit    <= 1'b0;
         rsp_fault     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_region    <= '0;
         rsp_mtype     <= '0;
         rsp_cacheable <= 1'b0;
         rsp_shareable <= 1'b0;
         rsp_xn        <= 1'b0;
      end else begin
         rsp_valid <= acc_valid;
         if (acc_valid) begin
            rsp_permit    <= permit_c;
            rsp_fault     <= !permit_c;
            rsp_hit       <= unit_en_q && any_hit;
            rsp_region    <= (unit_en_q && any_hit) ? sel_idx : '0;
            rsp_mtype     <= mtype_c;
            rsp_cacheable <= cach_c;
            rsp_shareable <= shr_c;
            rsp_xn        <= xn_c;
         end
      end
   end
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
   parameter int NUM_REGIONS = 16,
   parameter int IDX_W       = 4,
   parameter int CIDX_W      = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [1:0]        acc_kind,
   input logic              acc_priv,
   input logic              cfg_wr,
   input logic [CIDX_W-1:0] cfg_idx,
   input logic              cfg_reject,
   input logic              unit_en_q,
   input logic              rsp_valid,
   input logic              rsp_permit,
   input logic              rsp_fault,
   input logic              rsp_hit,
   input logic [IDX_W-1:0]  rsp_region,
   input logic [1:0]        rsp_mtype,
   input logic              rsp_cacheable,
   input logic              rsp_shareable,
   input logic              rsp_xn
);
   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid); // R11
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rsp_valid); // R11
   AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault != rsp_permit)); // R11
   AST_BAD_INDEX_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_idx >= CIDX_W'(NUM_REGIONS)) |=> cfg_reject); // R1
   AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(unit_en_q)) |-> (rsp_permit && !rsp_hit)); // R6
   AST_UNPRIV_MISS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit && $past(unit_en_q) && !$past(acc_priv)) |-> rsp_fault); // R9
   AST_XN_FETCH_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && rsp_xn && $past(acc_kind) == 2'd2) |-> rsp_fault); // R8
   AST_MISS_ATTRS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_mtype == 2'd0 && rsp_region == '0 &&
                                   !rsp_cacheable && !rsp_shareable && !rsp_xn)); // R11
   AST_ORDERED_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && rsp_mtype != 2'd2) |-> (rsp_shareable && !rsp_cacheable)); // R10
endmodule

bind prc_region_check prc_checker #(
   .NUM_REGIONS(NUM_REGIONS),
   .IDX_W      (IDX_W),
   .CIDX_W     (CIDX_W)
) u_prc_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_valid    (acc_valid),
   .acc_kind     (acc_kind),
   .acc_priv     (acc_priv),
   .cfg_wr       (cfg_wr),
   .cfg_idx      (cfg_idx),
   .cfg_reject   (cfg_reject),
   .unit_en_q    (unit_en_q),
   .rsp_valid    (rsp_valid),
   .rsp_permit   (rsp_permit),
   .rsp_fault    (rsp_fault),
   .rsp_hit      (rsp_hit),
   .rsp_region   (rsp_region),
   .rsp_mtype    (rsp_mtype),
   .rsp_cacheable(rsp_cacheable),
   .rsp_shareable(rsp_shareable),
   .rsp_xn       (rsp_xn)
);

// File: tb/tb_prc_region_check.sv
module tb_prc_region_check;
   localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_FE = 2'd2;
   localparam logic [1:0] T_SO = 2'd0, T_DV = 2'd1, T_NM = 2'd2;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_priv = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_kind = '0;
   logic        cfg_wr = 1'b0, cfg_en = 1'b0, cfg_b = 1'b0, cfg_c = 1'b0;
   logic        cfg_s = 1'b0, cfg_xn = 1'b0;
   logic [4:0]  cfg_idx = '0, cfg_size = '0;
   logic [31:0] cfg_base = '0;
   logic [2:0]  cfg_tex = '0, cfg_ap = '0;
   logic [7:0]  cfg_srd = '0;
   logic        ctl_wr = 1'b0, ctl_unit_en = 1'b0, ctl_bg_en = 1'b0;
   logic        cfg_reject, rsp_valid, rsp_permit, rsp_fault, rsp_hit;
   logic [3:0]  rsp_region;
   logic [1:0]  rsp_mtype;
   logic        rsp_cacheable, rsp_shareable, rsp_xn;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [10:0] vec;
      string       req;
   } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   prc_region_check dut (.*);

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: pops one expectation per response.
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         logic [10:0] got;
         got = {rsp_permit, rsp_hit, rsp_region, rsp_mtype,
                rsp_cacheable, rsp_shareable, rsp_xn};
         if (sb_q.size() == 0) check(1'b0, "R11 unexpected response", 32'(got), 32'h0);
         else begin
            exp_t e;
            e = sb_q.pop_front();
            check(got == e.vec && rsp_fault == !e.vec[10], e.req, 32'(got), 32'(e.vec));
         end
      end
   end

   task automatic access(input logic [31:0] a, input logic [1:0] k, input bit p,
                         input bit perm, input bit hit, input logic [3:0] reg_n,
                         input logic [1:0] mt, input bit ca, input bit sh, input bit xn,
                         input string req);
      exp_t e;
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p;
      e.vec = {perm, hit, reg_n, mt, ca, sh, xn};
      e.req = req;
      sb_q.push_back(e);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic region(input logic [4:0] idx, input logic [31:0] base, input logic [4:0] code,
                         input bit en, input bit b, input bit c, input bit s, input bit xn,
                         input logic [2:0] tex, input logic [2:0] ap, input logic [7:0] srd,
                         input bit exp_rej, input string req);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = idx; cfg_base = base; cfg_size = code;
      cfg_en = en; cfg_b = b; cfg_c = c; cfg_s = s; cfg_xn = xn;
      cfg_tex = tex; cfg_ap = ap; cfg_srd = srd;
      @(negedge clk);
      cfg_wr = 1'b0;
      check(cfg_reject == exp_rej, req, 32'(cfg_reject), 32'(exp_rej));
   endtask

   task automatic control(input bit u, input bit bg);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_unit_en = u; ctl_bg_en = bg;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R6 reset rsp_valid", 32'(rsp_valid), 0);
      check(cfg_reject == 1'b0, "R6 reset cfg_reject", 32'(cfg_reject), 0);
      check(rsp_permit == 1'b0, "R6 reset rsp_permit", 32'(rsp_permit), 0);
      // Unit disabled after reset: everything allowed, no hit
      access(32'h0010_0040, K_WR, 0, 1, 0, 0, T_SO, 0, 0, 0, "R6 disabled unit permits");

      region(0,  32'h0000_0000, 17, 1, 1, 1, 0, 0, 3'd1, 3'd3, 8'h00, 0, "R2 r0 4MB write");
      region(1,  32'h0010_0000, 15, 1, 1, 0, 0, 1, 3'd0, 3'd6, 8'h00, 0, "R2 r1 1MB write");
      region(2,  32'h0020_0000, 11, 1, 0, 0, 0, 0, 3'd0, 3'd1, 8'h02, 0, "R5 r2 64KB write");
      region(3,  32'h0030_0000,  7, 1, 0, 0, 0, 0, 3'd1, 3'd2, 8'h00, 0, "R4 r3 4KB write");
      region(16, 32'h0000_0000,  5, 1, 0, 0, 0, 0, 3'd1, 3'd3, 8'h00, 1, "R1 index 16 rejected");
      region(4,  32'h0050_0080,  3, 1, 0, 0, 0, 0, 3'd1, 3'd3, 8'h00, 1, "R3 misaligned rejected");
      region(4,  32'h0050_0000, 28, 1, 0, 0, 0, 0, 3'd1, 3'd3, 8'h00, 1, "R2 code 28 rejected");

      control(1, 0);
      access(32'h0000_1000, K_RD, 0, 1, 1, 0, T_NM, 1, 0, 0, "R7 ap3 user read");
      access(32'h0000_1000, K_WR, 0, 1, 1, 0, T_NM, 1, 0, 0, "R7 ap3 user write");
      access(32'h0010_0040, K_RD, 0, 1, 1, 1, T_DV, 0, 1, 1, "R4 r1 over r0, R10 device");
      access(32'h0010_0040, K_WR, 1, 0, 1, 1, T_DV, 0, 1, 1, "R7 ap6 write denied");
      access(32'h0010_0040, K_FE, 1, 0, 1, 1, T_DV, 0, 1, 1, "R8 fetch from xn region");
      access(32'h0020_0010, K_RD, 0, 0, 1, 2, T_SO, 0, 1, 0, "R7 ap1 user read denied");
      access(32'h0020_0010, K_WR, 1, 1, 1, 2, T_SO, 0, 1, 0, "R7 ap1 priv write");
      access(32'h0020_2010, K_RD, 1, 1, 1, 0, T_NM, 1, 0, 0, "R5 masked subregion falls to r0");
      access(32'h0020_4010, K_RD, 1, 1, 1, 2, T_SO, 0, 1, 0, "R5 unmasked subregion hits r2");
      access(32'h0030_0800, K_WR, 0, 0, 1, 3, T_NM, 0, 0, 0, "R7 ap2 user write denied");
      access(32'h0030_0800, K_RD, 0, 1, 1, 3, T_NM, 0, 0, 0, "R10 normal non-cacheable");
      access(32'h0030_0800, K_FE, 0, 1, 1, 3, T_NM, 0, 0, 0, "R8 fetch without xn");
      access(32'h0060_0000, K_RD, 1, 0, 0, 0, T_SO, 0, 0, 0, "R9 priv miss no background");
      access(32'h0050_0080, K_RD, 1, 0, 0, 0, T_SO, 0, 0, 0, "R3 rejected write left table");

      control(1, 1);
      access(32'h0060_0000, K_RD, 1, 1, 0, 0, T_SO, 0, 0, 0, "R9 priv miss with background");
      access(32'h0060_0000, K_RD, 0, 0, 0, 0, T_SO, 0, 0, 0, "R9 user miss faults");

      region(15, 32'h0000_0000, 27, 1, 0, 0, 0, 0, 3'd0, 3'd4, 8'h00, 0, "R2 r15 4GB write");
      access(32'h0010_0040, K_RD, 1, 1, 1, 15, T_SO, 0, 1, 0, "R4 r15 wins, R7 ap4 priv read");
      access(32'h0010_0040, K_RD, 0, 0, 1, 15, T_SO, 0, 1, 0, "R7 ap4 user read denied");
      access(32'hFFFF_FFF0, K_WR, 1, 0, 1, 15, T_SO, 0, 1, 0, "R7 ap4 priv write denied");
      region(15, 32'h0000_0000, 27, 0, 0, 0, 0, 0, 3'd0, 3'd4, 8'h00, 0, "R12 r15 disabled");
      access(32'h0010_0040, K_RD, 0, 1, 1, 1, T_DV, 0, 1, 1, "R12 disabled r15 skipped");

      control(0, 0);
      access(32'h0010_0040, K_WR, 0, 1, 0, 0, T_SO, 0, 0, 0, "R6 unit off again");

      repeat (3) @(negedge clk);
      check(sb_q.size() == 0, "R11 all responses seen", 32'(sb_q.size()), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule